// File: doc/BRIEF.md
# Guarded single-channel DMA copy engine

This block moves a run of words from a source address to a destination address, one read and one write at a time. Every access is first checked against a single protection region. Software starts a transfer with a one-cycle write strobe. The strobe carries the source address, the destination address, the word count and a stepping direction. The protection region's address and its configuration byte arrive on input ports. They are sampled into private registers in the same cycle that the transfer is accepted, and the permission logic looks only at that sampled copy until the transfer has ended.

A transfer runs read, write, read, write, and so on. A read is issued at the source and the returned word is written to the destination in the following cycle. Both addresses then step up or down. If an access falls outside the region, or lacks the needed right, the engine stops before issuing that access and raises a fault that holds until software clears it. A transfer that finishes normally raises a done flag that holds in the same way. Because the region is frozen at start, changing the protection ports in the middle of a transfer cannot widen or move the area the transfer may touch.

Top module: `dma_guard`

## Requirements
- R1: A `ctl_wr` pulse while idle starts a transfer of `ctl_len` words. Word k is read at source+k·s, and the returned data is written to destination+k·s in the next cycle, where s is +1 for `ctl_dir`=0 and −1 for `ctl_dir`=1. A count of zero goes straight to done with no memory access.
- R2: `prot_addr` and `prot_cfg` are sampled only when a transfer is accepted. Changes to them while the transfer is running have no effect on which accesses are allowed.
- R3: Configuration encoding: bit0 grants read, bit1 grants write and bit2 grants execute. Bits 4:3 give the match mode, where 2'b11 is a naturally aligned power-of-two region. Under that mode, if the sampled address has t trailing ones, address bits 0..t are ignored in the comparison, so an all-ones address matches every address. Every other mode value denies all accesses.
- R4: A read needs the read right and a region match on the source address. A write needs the write right and a region match on the destination address. The execute right alone grants neither.
- R5: On the first access that fails R4, no memory request is issued for it and `fault_o` rises. Words already written stay written, and no further accesses follow.
- R6: `done_o` and `fault_o` hold until a `sts_clr` pulse, which returns the engine to idle. While a transfer is running or a status flag is held, `ctl_wr` is ignored.
- R7: After reset the engine is idle, with `busy_o`, `done_o`, `fault_o` and `mem_req` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Start strobe (control write) |
| ctl_src | input | AW | Source word address |
| ctl_dst | input | AW | Destination word address |
| ctl_len | input | LW | Number of words |
| ctl_dir | input | 1 | 0: addresses ascend, 1: descend |
| sts_clr | input | 1 | Clears done/fault, returns to idle |
| prot_addr | input | AW | Live protection region address |
| prot_cfg | input | 8 | Live protection configuration byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky completion flag |
| fault_o | output | 1 | Sticky permission fault flag |

## Verification
The hardest case to reach from the ports is a protection setting that changes between the check that accepted a transfer and the later accesses of that same transfer. The stimulus changes `prot_addr` and `prot_cfg` in the first read cycle, before the edge that would act on them. It does this in three ways: it moves the region away from an allowed copy, it widens the region under a copy that will run off its edge, and it grants rights to a transfer that starts denied. The bench then checks, from the memory contents and the write count, that the outcome follows the sampled settings. Partial aborts are also reached: some transfers are chosen so that the destination leaves the region after a known number of words, and others have read rights but no write rights.

// File: rtl/dma_guard.sv
module dma_guard #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [AW-1:0] ctl_src,
  input  logic [AW-1:0] ctl_dst,
  input  logic [LW-1:0] ctl_len,
  input  logic          ctl_dir,
  input  logic          sts_clr,
  input  logic [AW-1:0] prot_addr,
  input  logic [7:0]    prot_cfg,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy_o,
  output logic          done_o,
  output logic          fault_o
);
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_STORE, S_DONE, S_ABORT} st_t;

  st_t           st;
  logic [AW-1:0] src_q, dst_q, pa_q;
  logic [LW-1:0] rem_q;
  logic          dir_q;
  logic [7:0]    cfg_q;
  logic [AW-1:0] care;
  logic          napot, rd_ok, wr_ok;

  always_comb begin
    logic ones;
    ones = 1'b1;
    for (int i = 0; i < AW; i++) begin
      care[i] = ~ones;
      ones    = ones & pa_q[i];
    end
  end

  assign napot = (cfg_q[4:3] == 2'b11);
  assign rd_ok = napot && cfg_q[0] && (((src_q ^ pa_q) & care) == '0);
  assign wr_ok = napot && cfg_q[1] && (((dst_q ^ pa_q) & care) == '0);

  assign mem_req   = (st == S_LOAD && rd_ok) || (st == S_STORE && wr_ok);
  assign mem_we    = (st == S_STORE) && wr_ok;
  assign mem_addr  = (st == S_STORE) ? dst_q : src_q;
  assign mem_wdata = mem_rdata;
  assign busy_o    = (st == S_LOAD) || (st == S_STORE);
  assign done_o    = (st == S_DONE);
  assign fault_o   = (st == S_ABORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
      dir_q <= 1'b0;
      pa_q  <= '0;
      cfg_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (ctl_wr) begin
          src_q <= ctl_src;
          dst_q <= ctl_dst;
          rem_q <= ctl_len;
          dir_q <= ctl_dir;
          pa_q  <= prot_addr;
          cfg_q <= prot_cfg;
          st    <= (ctl_len == '0) ? S_DONE : S_LOAD;
        end
        S_LOAD:  st <= rd_ok ? S_STORE : S_ABORT;
        S_STORE: if (!wr_ok) st <= S_ABORT;
        else begin
          src_q <= dir_q ? src_q - 1'b1 : src_q + 1'b1;
          dst_q <= dir_q ? dst_q - 1'b1 : dst_q + 1'b1;
          rem_q <= rem_q - 1'b1;
          st    <= (rem_q == LW'(1)) ? S_DONE : S_LOAD;
        end
        S_DONE, S_ABORT: if (sts_clr) st <= S_IDLE;
        default: st <= S_ABORT;
      endcase
    end
  end
endmodule

// File: rtl/dma_guard_chk.sv
module dma_guard_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          busy_o,
  input logic          done_o,
  input logic          fault_o,
  input logic          sts_clr,
  input logic [AW-1:0] pa_q,
  input logic [7:0]    cfg_q
);
  AST_PROT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && busy_o) |-> ($stable(pa_q) && $stable(cfg_q))); // R2
  AST_RD_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (cfg_q[0] && cfg_q[4:3] == 2'b11)); // R4
  AST_WR_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (cfg_q[1] && cfg_q[4:3] == 2'b11)); // R4
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req); // R5
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !sts_clr) |=> fault_o); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !sts_clr) |=> done_o); // R6
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fault_o)); // R6
endmodule

bind dma_guard dma_guard_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .sts_clr(sts_clr),
  .pa_q(pa_q), .cfg_q(cfg_q)
);

// File: tb/dma_guard_tb_top.sv
`timescale 1ns/1ps
module dma_guard_tb_top;
  localparam int AW = 8, DW = 16, LW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 1'b0, ctl_dir = 1'b0, sts_clr = 1'b0;
  logic [AW-1:0] ctl_src = '0, ctl_dst = '0, prot_addr = '0;
  logic [LW-1:0] ctl_len = '0;
  logic [7:0] prot_cfg = '0;
  logic mem_req, mem_we, busy_o, done_o, fault_o;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [DW-1:0] mem [256];
  int wr_cnt = 0;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dma_guard #(.AW(AW), .DW(DW), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_src(ctl_src),
    .ctl_dst(ctl_dst), .ctl_len(ctl_len), .ctl_dir(ctl_dir),
    .sts_clr(sts_clr), .prot_addr(prot_addr), .prot_cfg(prot_cfg),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy_o(busy_o),
    .done_o(done_o), .fault_o(fault_o));

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
    if (mem_req && mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [DW-1:0] pat(int a);
    return DW'(16'h1000 + a * 7);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0] src, dst; logic [5:0] len; logic dir;
    logic [7:0] pa, cfg; logic abort; logic [5:0] copied;
  } vec_t;

  // cfg: bit0 R, bit1 W, bit2 X, bits4:3 mode (11 = aligned power-of-two)
  localparam vec_t VECS [9] = '{
    '{8'h40, 8'h48, 6'd4, 1'b0, 8'h47, 8'h1B, 1'b0, 6'd4},
    '{8'h4F, 8'h47, 6'd3, 1'b1, 8'h47, 8'h1B, 1'b0, 6'd3},
    '{8'h40, 8'h41, 6'd0, 1'b0, 8'h47, 8'h1B, 1'b0, 6'd0},
    '{8'h40, 8'h44, 6'd2, 1'b0, 8'h47, 8'h19, 1'b1, 6'd0},
    '{8'h40, 8'h44, 6'd2, 1'b0, 8'h47, 8'h1C, 1'b1, 6'd0},
    '{8'h40, 8'h44, 6'd2, 1'b0, 8'h47, 8'h03, 1'b1, 6'd0},
    '{8'h4C, 8'h4E, 6'd4, 1'b0, 8'h47, 8'h1B, 1'b1, 6'd2},
    '{8'h40, 8'h44, 6'd2, 1'b0, 8'h47, 8'h0B, 1'b1, 6'd0},
    '{8'h10, 8'h80, 6'd3, 1'b0, 8'hFF, 8'h1B, 1'b0, 6'd3}
  };

  task automatic run_xfer(vec_t v, bit chg, logic [7:0] cpa, logic [7:0] ccfg,
                          bit poke, string req);
    int s, d, step;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    @(negedge clk);
    wr_cnt    = 0;
    ctl_src   = v.src; ctl_dst = v.dst; ctl_len = v.len; ctl_dir = v.dir;
    prot_addr = v.pa;  prot_cfg = v.cfg;
    ctl_wr    = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
    if (chg) begin prot_addr = cpa; prot_cfg = ccfg; end
    if (poke) begin
      ctl_wr = 1'b1; ctl_src = 8'h00; ctl_dst = 8'h01; ctl_len = 6'd1;
      @(negedge clk);
      ctl_wr = 1'b0;
    end
    for (int c = 0; c < 300 && !(done_o || fault_o); c++) @(negedge clk);
    chk(done_o == !v.abort, req, "done flag", done_o, !v.abort);
    chk(fault_o == v.abort, req, "fault flag", fault_o, v.abort);
    chk(wr_cnt == v.copied, req, "words written", wr_cnt, v.copied);
    step = v.dir ? -1 : 1;
    s = v.src; d = v.dst;
    for (int k = 0; k < v.copied; k++) begin
      chk(mem[d & 255] == pat(s & 255), "R1", "copied word", mem[d & 255], pat(s & 255));
      s += step; d += step;
    end
    if (v.abort)
      chk(mem[d & 255] == pat(d & 255), "R5", "word after fault untouched",
          mem[d & 255], pat(d & 255));
    if (poke)
      chk(mem[1] == pat(1), "R6", "start while busy ignored", mem[1], pat(1));
    ctl_wr = 1'b1; ctl_src = 8'h00; ctl_dst = 8'h01; ctl_len = 6'd1;
    @(negedge clk);
    ctl_wr = 1'b0;
    @(negedge clk);
    chk(done_o == !v.abort && fault_o == v.abort && wr_cnt == v.copied,
        "R6", "status held, start ignored", {done_o, fault_o}, {!v.abort, v.abort});
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
    chk(!busy_o && !done_o && !fault_o, "R6", "clear returns idle",
        {busy_o, done_o, fault_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !fault_o && !mem_req, "R7", "reset state",
        {busy_o, done_o, fault_o, mem_req}, 0);
    foreach (VECS[i])
      run_xfer(VECS[i], 1'b0, 8'h00, 8'h00, 1'b0, i == 3 || i == 4 ? "R4" :
               i == 5 || i == 7 ? "R3" : i == 6 ? "R5" : "R1");
    // R2: region moved away mid-transfer, copy stays in sampled region
    run_xfer('{8'h40, 8'h48, 6'd8, 1'b0, 8'h47, 8'h1B, 1'b0, 6'd8},
             1'b1, 8'h87, 8'h1B, 1'b0, "R2");
    // R2: region widened mid-transfer, still faults at sampled edge
    run_xfer('{8'h4C, 8'h4E, 6'd4, 1'b0, 8'h47, 8'h1B, 1'b1, 6'd2},
             1'b1, 8'hFF, 8'h1B, 1'b0, "R2");
    // R2: rights granted mid-transfer after denied start
    run_xfer('{8'h40, 8'h44, 6'd2, 1'b0, 8'h47, 8'h03, 1'b1, 6'd0},
             1'b1, 8'h47, 8'h1B, 1'b0, "R2");
    // R6: start strobe while busy is ignored
    run_xfer('{8'h40, 8'h48, 6'd4, 1'b0, 8'h47, 8'h1B, 1'b0, 6'd4},
             1'b0, 8'h00, 8'h00, 1'b1, "R6");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule